// File: doc/BRIEF.md
# Sixteen-Lane Memory Access Coalescer

This unit sits between the address stage of a sixteen-lane vector pipeline and the memory request port. It accepts one memory instruction at a time. The instruction carries a per-lane enable mask, a byte address for each lane, an access width code and a mode bit. The unit turns that instruction into the shortest run of aligned memory transactions that serves every enabled lane. Each transaction names an aligned base address, a length of 32, 64 or 128 bytes, and the set of lanes whose bytes it carries.

Work proceeds in rounds. Each round takes the lowest-numbered lane still waiting and finds the aligned segment that holds its address. It gathers every other waiting lane in that segment and then narrows the transaction to the smallest aligned block that still covers those lanes. The served lanes retire, and rounds continue until none is left. A single-cycle done pulse closes the instruction.

With the mode bit set, a stricter legacy rule applies. The instruction is merged only when every enabled lane k addresses the k-th element of one segment. Otherwise every enabled lane gets its own transaction.

Top module: `lane_coalescer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R2: An instruction is taken on a cycle where in_valid and in_ready are both high. in_ready stays low from the cycle after acceptance until the done pulse.
- R3: Every transaction includes the lowest-numbered lane that is still unserved. Transactions therefore appear in ascending order of their lowest lane.
- R4: Outside legacy mode, a transaction serves exactly the unserved lanes in the same aligned segment as that lowest lane. The segment size follows in_size: code 0 (1-byte access) gives 32 bytes, code 1 (2-byte) gives 64, and codes 2 (4-byte) and 3 (8-byte) give 128. Lane addresses are aligned to their access width.
- R5: out_len is coded 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes. It names the smallest aligned block, no larger than the segment, that holds every served lane. out_base is the lowest lane's address with the low bits cleared to that size.
- R6: Every enabled lane appears in exactly one transaction, and lanes outside in_mask appear in none.
- R7: A transaction is consumed only on a cycle with out_valid and out_ready both high. While out_ready is low, out_base, out_len and out_lanes hold their values.
- R8: done is high for one cycle, the cycle after the final transfer. With an all-zero mask, done comes the cycle after acceptance and no transaction is offered.
- R9: In legacy mode (in_strict = 1), the pattern holds when every enabled lane k lies in the lowest enabled lane's segment at offset k times the access width. In that case one transaction serves all enabled lanes, sized as in R5.
- R10: In legacy mode, when the pattern fails, each enabled lane is issued alone in ascending lane order. Each such transaction has out_len 0 and a base equal to the lane address aligned to 32 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to take an instruction |
| in_mask | input | LANES | Enabled lanes |
| in_addr | input | LANES*ADDR_W | Byte addresses, lane k at bits k*ADDR_W upward |
| in_size | input | 2 | Access width code: 0=1B, 1=2B, 2=4B, 3=8B |
| in_strict | input | 1 | Legacy sequential-pattern mode |
| out_valid | output | 1 | Transaction offered |
| out_ready | input | 1 | Consumer accepts the transaction |
| out_base | output | ADDR_W | Aligned base address |
| out_len | output | 2 | Length code: 0=32B, 1=64B, 2=128B |
| out_lanes | output | LANES | Lanes served by the transaction |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
Some properties are checked on every cycle:
- each offered transaction contains the lowest unserved lane and no lane that has already retired;
- the base is aligned to the stated length, and the length code is never 3;
- the payload holds steady under back-pressure;
- done lasts one cycle and follows the last transfer;
- a legacy-mode split offers one 32-byte lane at a time.

Other properties only the bench scenarios can show, because they need the full expected sequence:
- that the lane grouping is exactly right for each segment size;
- that the narrowing picks the smallest block;
- that the legacy pattern test accepts skipped lanes and rejects a swapped pair;
- that the transaction count is minimal.

// File: rtl/coal_pkg.sv
package coal_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } coal_state_e;

   typedef enum logic [1:0] {
      LEN_32  = 2'd0,
      LEN_64  = 2'd1,
      LEN_128 = 2'd2
   } txn_len_e;

   localparam int unsigned MIN_BLK_LG = 5;
   localparam int unsigned MAX_BLK_LG = 7;

   // log2 of the segment size for an access width code
   function automatic logic [2:0] seg_lg_of(input logic [1:0] sz);
      logic [2:0] r;
      case (sz)
         2'd0:    r = 3'd5;
         2'd1:    r = 3'd6;
         default: r = 3'd7;
      endcase
      return r;
   endfunction

   // offset mask inside a segment of the given log2 size
   function automatic logic [6:0] seg_off_mask(input logic [2:0] lg);
      logic [6:0] r;
      case (lg)
         3'd5:    r = 7'h1f;
         3'd6:    r = 7'h3f;
         default: r = 7'h7f;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/coal_lowest.sv
module coal_lowest #(
   parameter int unsigned N  = 16,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          found
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/coal_strict_check.sv
module coal_strict_check
   import coal_pkg::*;
#(
   parameter int unsigned LANES  = 16,
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0]        mask,
   input  logic [LANES*ADDR_W-1:0] addr_flat,
   input  logic [1:0]              size,
   output logic                    pattern_ok
);
   logic [LW-1:0]     first;
   logic              any;
   logic [ADDR_W-1:0] fa;
   logic [2:0]        slg;
   logic [6:0]        omask;
   logic [LANES-1:0]  lane_ok;

   coal_lowest #(.N(LANES)) u_first (.req(mask), .idx(first), .found(any));

   assign fa    = addr_flat[first*ADDR_W +: ADDR_W];
   assign slg   = seg_lg_of(size);
   assign omask = seg_off_mask(slg);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [ADDR_W-1:0] a;
      logic              same_seg;
      logic [6:0]        want;
      assign a = addr_flat[k*ADDR_W +: ADDR_W];
      always_comb begin
         case (slg)
            3'd5:    same_seg = (a[ADDR_W-1:5] == fa[ADDR_W-1:5]);
            3'd6:    same_seg = (a[ADDR_W-1:6] == fa[ADDR_W-1:6]);
            default: same_seg = (a[ADDR_W-1:7] == fa[ADDR_W-1:7]);
         endcase
      end
      assign want       = 7'(k) << size;
      assign lane_ok[k] = !mask[k] || (same_seg && ((a[6:0] & omask) == want));
   end

   assign pattern_ok = !any || (&lane_ok);
endmodule

// File: rtl/coal_round.sv
module coal_round
   import coal_pkg::*;
#(
   parameter int unsigned LANES  = 16,
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0]        pend,
   input  logic [LANES*ADDR_W-1:0] addr_flat,
   input  logic [1:0]              size,
   input  logic                    split,
   output logic                    any,
   output logic [LANES-1:0]        lanes,
   output logic [ADDR_W-1:0]       base,
   output txn_len_e                len
);
   logic [LW-1:0]     lead;
   logic [ADDR_W-1:0] la;
   logic [2:0]        slg;
   logic [LANES-1:0]  s5, s6, s7, in_seg, lead_oh;
   logic              all5, all6;

   coal_lowest #(.N(LANES)) u_lead (.req(pend), .idx(lead), .found(any));

   assign la      = addr_flat[lead*ADDR_W +: ADDR_W];
   assign slg     = seg_lg_of(size);
   assign lead_oh = {{(LANES-1){1'b0}}, 1'b1} << lead;

   for (genvar k = 0; k < LANES; k++) begin : g_cmp
      logic [ADDR_W-1:0] a;
      assign a     = addr_flat[k*ADDR_W +: ADDR_W];
      assign s5[k] = (a[ADDR_W-1:5] == la[ADDR_W-1:5]);
      assign s6[k] = (a[ADDR_W-1:6] == la[ADDR_W-1:6]);
      assign s7[k] = (a[ADDR_W-1:7] == la[ADDR_W-1:7]);
      always_comb begin
         case (slg)
            3'd5:    in_seg[k] = s5[k];
            3'd6:    in_seg[k] = s6[k];
            default: in_seg[k] = s7[k];
         endcase
      end
   end

   assign lanes = split ? lead_oh : (pend & in_seg);
   assign all5  = ((lanes & ~s5) == '0);
   assign all6  = ((lanes & ~s6) == '0);

   always_comb begin
      if (split || all5)   len = LEN_32;
      else if (all6)       len = LEN_64;
      else                 len = LEN_128;
   end

   always_comb begin
      case (len)
         LEN_32:  base = {la[ADDR_W-1:5], 5'b0};
         LEN_64:  base = {la[ADDR_W-1:6], 6'b0};
         default: base = {la[ADDR_W-1:7], 7'b0};
      endcase
   end
endmodule

// File: rtl/lane_coalescer.sv
module lane_coalescer
   import coal_pkg::*;
#(
   parameter int unsigned LANES     = 16,
   parameter int unsigned ADDR_W    = 32,
   parameter bit          STRICT_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES-1:0]        in_mask,
   input  logic [LANES*ADDR_W-1:0] in_addr,
   input  logic [1:0]              in_size,
   input  logic                    in_strict,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [ADDR_W-1:0]       out_base,
   output logic [1:0]              out_len,
   output logic [LANES-1:0]        out_lanes,
   output logic                    done
);
   if (LANES < 2 || LANES > 16) begin : g_bad_lanes
      $error("lane_coalescer: LANES must lie in 2..16");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("lane_coalescer: ADDR_W must be at least 8");
   end

   coal_state_e             st;
   logic [LANES-1:0]        pend;
   logic [LANES*ADDR_W-1:0] addr_q;
   logic [1:0]              size_q;
   logic                    split_q;
   logic                    pat_ok;
   logic                    rnd_any;
   logic [LANES-1:0]        rnd_lanes;
   logic [ADDR_W-1:0]       rnd_base;
   txn_len_e                rnd_len;
   logic                    accept, xfer;

   if (STRICT_EN) begin : g_strict
      coal_strict_check #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
         .mask(in_mask), .addr_flat(in_addr), .size(in_size), .pattern_ok(pat_ok)
      );
   end else begin : g_no_strict
      assign pat_ok = 1'b1;
   end

   coal_round #(.LANES(LANES), .ADDR_W(ADDR_W)) u_round (
      .pend(pend), .addr_flat(addr_q), .size(size_q), .split(split_q),
      .any(rnd_any), .lanes(rnd_lanes), .base(rnd_base), .len(rnd_len)
   );

   assign in_ready  = (st == ST_IDLE);
   assign accept    = in_valid && in_ready;
   assign out_valid = (st == ST_RUN) && rnd_any;
   assign done      = (st == ST_RUN) && !rnd_any;
   assign xfer      = out_valid && out_ready;
   assign out_base  = rnd_base;
   assign out_len   = rnd_len;
   assign out_lanes = rnd_lanes;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         pend    <= '0;
         addr_q  <= '0;
         size_q  <= '0;
         split_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (accept) begin
               st      <= ST_RUN;
               pend    <= in_mask;
               addr_q  <= in_addr;
               size_q  <= in_size;
               split_q <= in_strict && !pat_ok;
            end
            default: begin
               if (xfer) pend <= pend & ~rnd_lanes;
               if (done) st   <= ST_IDLE;
            end
         endcase
      end
   end

   logic [LANES-1:0]  low_bit;
   logic [ADDR_W-1:0] align_mask;
   assign low_bit    = pend & (~pend + 1'b1);
   assign align_mask = (out_len == 2'd0) ? ADDR_W'(32'h1f) :
                       (out_len == 2'd1) ? ADDR_W'(32'h3f) : ADDR_W'(32'h7f);

   AST_LEAD_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_lanes & low_bit) != '0)); // R3
   AST_LANES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_lanes & ~pend) == '0)); // R6
   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_base & align_mask) == '0)); // R5
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len != 2'd3)); // R5
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_lanes) && $stable(out_base) && $stable(out_len))); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> done); // R8
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !in_ready); // R2
   AST_SPLIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (split_q && out_valid) |-> ($onehot(out_lanes) && out_len == 2'd0)); // R10
endmodule

// File: tb/lane_coalescer_test.sv
`timescale 1ns/1ps
module lane_coalescer_test;
   localparam int L = 16;
   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_strict = 1'b0, out_ready = 1'b0;
   logic [L-1:0] in_mask = '0;
   logic [1:0] in_size = '0;
   logic [L*AW-1:0] in_addr;
   logic in_ready, out_valid, done;
   logic [AW-1:0] out_base;
   logic [1:0] out_len;
   logic [L-1:0] out_lanes;

   logic [AW-1:0] addr [L];
   always_comb for (int k = 0; k < L; k++) in_addr[k*AW +: AW] = addr[k];

   always #2.5 clk = ~clk;

   lane_coalescer #(.LANES(L), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_mask(in_mask), .in_addr(in_addr), .in_size(in_size), .in_strict(in_strict),
      .out_valid(out_valid), .out_ready(out_ready), .out_base(out_base),
      .out_len(out_len), .out_lanes(out_lanes), .done(done)
   );

   int n_run = 0, n_fail = 0;

   logic [AW-1:0] e_base [L];
   logic [1:0]    e_len  [L];
   logic [L-1:0]  e_lanes[L];
   int            e_n;
   string         e_tag;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Expected transaction list, computed from the requirement text
   task automatic build_expected(input logic [L-1:0] m, input logic [1:0] sz, input bit st);
      int slg, lead, blk;
      bit ok, fit;
      logic [L-1:0] pend, grp;
      slg = (sz >= 2) ? 7 : 5 + int'(sz);
      lead = -1;
      for (int k = L - 1; k >= 0; k--) if (m[k]) lead = k;
      ok = 1'b1;
      for (int k = 0; k < L; k++)
         if (m[k] && lead >= 0)
            if ((addr[k] >> slg) != (addr[lead] >> slg) ||
                (addr[k] % (32'd1 << slg)) != (32'(k) << sz)) ok = 1'b0;
      e_n = 0;
      if (st && !ok) begin
         e_tag = "R10";
         for (int k = 0; k < L; k++) if (m[k]) begin
            e_base[e_n] = addr[k] & ~32'h1f; e_len[e_n] = 2'd0;
            e_lanes[e_n] = L'(1) << k; e_n++;
         end
      end else begin
         e_tag = st ? "R9" : "R4";
         pend = m;
         while (pend != '0) begin
            for (int k = L - 1; k >= 0; k--) if (pend[k]) lead = k;
            grp = '0;
            for (int k = 0; k < L; k++)
               if (pend[k] && (addr[k] >> slg) == (addr[lead] >> slg)) grp[k] = 1'b1;
            blk = slg;
            for (int b = slg; b >= 5; b--) begin
               fit = 1'b1;
               for (int k = 0; k < L; k++)
                  if (grp[k] && (addr[k] >> b) != (addr[lead] >> b)) fit = 1'b0;
               if (fit) blk = b;
            end
            e_base[e_n] = (addr[lead] >> blk) << blk;
            e_len[e_n] = 2'(blk - 5);
            e_lanes[e_n] = grp; e_n++;
            pend = pend & ~grp;
         end
      end
   endtask

   task automatic run_op(input logic [L-1:0] m, input logic [1:0] sz, input bit st, input int stall_pct);
      int idx, hs_iter;
      bit stalled, seen_done;
      logic [AW-1:0] s_base; logic [1:0] s_len; logic [L-1:0] s_lanes;
      build_expected(m, sz, st);
      @(negedge clk);
      in_valid = 1'b1; in_mask = m; in_size = sz; in_strict = st;
      @(negedge clk);
      in_valid = 1'b0;
      idx = 0; hs_iter = -1; stalled = 1'b0; seen_done = 1'b0;
      for (int i = 0; i < 300; i++) begin
         out_ready = ($urandom_range(99) >= stall_pct);
         #1;
         if (i == 0) chk(in_ready == 1'b0, "R2", "in_ready while busy", in_ready, 0);
         if (stalled)
            chk(out_valid && out_base == s_base && out_len == s_len && out_lanes == s_lanes,
                "R7", "held payload", {out_base, out_lanes}, {s_base, s_lanes});
         if (done) begin
            seen_done = 1'b1;
            chk(i == hs_iter + 1, "R8", "done cycle", i, hs_iter + 1);
            break;
         end
         stalled = out_valid && !out_ready;
         s_base = out_base; s_len = out_len; s_lanes = out_lanes;
         if (out_valid && out_ready) begin
            if (idx < e_n) begin
               chk(out_lanes == e_lanes[idx], e_tag, "R3 lanes", out_lanes, e_lanes[idx]);
               chk(out_base == e_base[idx] && out_len == e_len[idx], "R5", "base/len",
                   {out_base, 6'd0, out_len}, {e_base[idx], 6'd0, e_len[idx]});
            end
            idx++;
            hs_iter = i;
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(seen_done, "R8", "done seen", seen_done, 1);
      chk(idx == e_n, "R6", "transaction count", idx, e_n);
   endtask

   task automatic fill_seq(input logic [AW-1:0] b, input logic [1:0] sz);
      for (int k = 0; k < L; k++) addr[k] = b + (32'(k) << sz);
   endtask

   task automatic fill_rand(input logic [1:0] sz, input int win);
      logic [AW-1:0] b;
      b = {$urandom_range(255), 12'h000};
      for (int k = 0; k < L; k++) addr[k] = b + ((32'($urandom_range(win - 1))) << sz);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [AW-1:0] t;
      for (int k = 0; k < L; k++) addr[k] = '0;
      repeat (3) @(posedge clk);
      #1;
      chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
          {in_ready, out_valid, done}, 3'b100);
      @(negedge clk); rst_n = 1'b1;

      // R8: empty mask in both modes
      run_op('0, 2'd2, 1'b0, 0);
      run_op('0, 2'd1, 1'b1, 0);

      // R9 and R4: sequential access per width, both modes, full and partial masks
      for (int sz = 0; sz < 4; sz++) begin
         for (int st = 0; st < 2; st++) begin
            fill_seq(32'h0001_0400, 2'(sz));
            run_op('1, 2'(sz), st[0], 0);
            run_op(16'h00ff, 2'(sz), st[0], 20);
            run_op(16'h5a3c, 2'(sz), st[0], 40);
         end
      end

      // R10: swap two lanes in a sequential pattern
      for (int sz = 0; sz < 4; sz++) begin
         fill_seq(32'h0002_0000, 2'(sz));
         t = addr[3]; addr[3] = addr[4]; addr[4] = t;
         run_op('1, 2'(sz), 1'b1, 25);
         run_op('1, 2'(sz), 1'b0, 25);
         run_op(16'hffe7, 2'(sz), 1'b1, 0);
      end

      // R5: every lane at one address narrows to 32 bytes
      for (int k = 0; k < L; k++) addr[k] = 32'h0003_0068;
      run_op('1, 2'd3, 1'b0, 0);

      // R3, R4, R5, R6, R7: scattered addresses, random masks, back-pressure
      for (int sz = 0; sz < 4; sz++) begin
         for (int n = 0; n < 60; n++) begin
            fill_rand(2'(sz), (n % 3 == 0) ? 16 : 96);
            run_op(L'($urandom), 2'(sz), n[0], 35);
         end
      end

      // R10: strict mode on scattered addresses
      for (int n = 0; n < 20; n++) begin
         fill_rand(2'd2, 64);
         run_op('1, 2'd2, 1'b1, 10);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule